// File: doc/BRIEF.md
# Highway and Farm Road Intersection Light Controller

This block sequences the lights at a crossing where a busy highway meets a lightly used farm road. The highway rests on green. A car sensor on the farm road asks for a turn. The highway gives up green only after it has held green for a full long interval. The farm road keeps green while cars are still sensed, and never longer than the long interval. Each road passes through a yellow phase of one short interval before the other road gets green.

A restartable interval timer is part of the block. The controller restarts it on every phase change and on reset. It reports when the short interval has elapsed and when the long interval has elapsed. Both lengths are parameters given in clock cycles. The car sensor is assumed to be already synchronised and debounced, and the lamp outputs drive the lamp drivers directly.

Top module: `hwy_farm_signal_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block enters the highway-green phase and restarts the timer. With car present from release onward, the highway shows green for exactly LONG_CYC+1 cycles after release before yellow.
- R2: In every cycle each road drives exactly one of its green, yellow and red outputs high. The lamp patterns {hwy_grn,hwy_yel,hwy_red,farm_grn,farm_yel,farm_red} are: highway green = 100001, highway yellow = 010001, farm green = 001100, farm yellow = 001010.
- R3: Highway green moves to highway yellow only at an edge where the long interval has elapsed and `farm_car` is high. In every other case it stays green, so a waiting car never cuts the highway green short.
- R4: Highway yellow lasts SHORT_CYC+1 cycles and then moves to farm green, whatever `farm_car` does.
- R5: Farm green moves to farm yellow at the first edge where `farm_car` is low or the long interval has elapsed. It therefore lasts at most LONG_CYC+1 cycles, and only one cycle if no car is present on entry.
- R6: Farm yellow lasts SHORT_CYC+1 cycles and then returns to highway green, whatever `farm_car` does.
- R7: The timer clears at each phase change. Its short and long elapsed flags rise SHORT_CYC and LONG_CYC cycles after the clear, and stay high until the next clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| farm_car | input | 1 | High while a car waits on the farm road |
| hwy_grn | output | 1 | Highway green lamp |
| hwy_yel | output | 1 | Highway yellow lamp |
| hwy_red | output | 1 | Highway red lamp |
| farm_grn | output | 1 | Farm road green lamp |
| farm_yel | output | 1 | Farm road yellow lamp |
| farm_red | output | 1 | Farm road red lamp |

## Verification
The sensor is driven in several patterns, and each one separates the exit conditions of the phases:
- A car that stays present through a whole cycle of phases shows that farm green ends on the long interval.
- A car that arrives early in highway green shows that the highway minimum green holds.
- A car that is gone when farm green starts gives a one-cycle farm green.
- A car that leaves in the middle of farm green ends farm green early.
- Sensor changes during the yellow phases must leave yellow timing unchanged.

A reset applied during farm green must give the highway a fresh full green.

// File: rtl/hwy_farm_pkg.sv
// Shared types for the intersection light controller.
// Assumes: four phases, one lamp triple per road.
package hwy_farm_pkg;

    typedef enum logic [1:0] {
        PH_HWY_GO    = 2'd0,
        PH_HWY_WARN  = 2'd1,
        PH_FARM_GO   = 2'd2,
        PH_FARM_WARN = 2'd3
    } phase_t;

    typedef struct packed {
        logic grn;
        logic yel;
        logic red;
    } lamp_t;

endpackage

// File: rtl/hfl_interval_timer.sv
// Restartable interval timer. It counts cycles since the last restart and
// saturates at the larger of the two lengths.
// Assumes: SHORT_CYC >= 1 and LONG_CYC >= 1. Reset acts as a restart.
module hfl_interval_timer #(
    parameter int SHORT_CYC = 3,
    parameter int LONG_CYC  = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic short_done,
    output logic long_done
);
    localparam int LIMIT = (SHORT_CYC > LONG_CYC) ? SHORT_CYC : LONG_CYC;
    localparam int CW    = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LIMIT_V = CW'(LIMIT);
    localparam logic [CW-1:0] SHORT_V = CW'(SHORT_CYC);
    localparam logic [CW-1:0] LONG_V  = CW'(LONG_CYC);

    logic [CW-1:0] cnt;

    // Count cycles since restart, holding at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n || restart)
            cnt <= '0;
        else if (cnt != LIMIT_V)
            cnt <= cnt + 1'b1;
    end

    // Elapsed flags compare the count against each length.
    always_comb begin
        short_done = (cnt >= SHORT_V);
        long_done  = (cnt >= LONG_V);
    end

    // R7
    restart_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (!short_done && !long_done));
    // R7
    long_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (long_done && !restart) |=> long_done);
    // R7
    short_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (short_done && !restart) |=> short_done);

endmodule

// File: rtl/hfl_phase_fsm.sv
// Four-phase sequencer. It changes phase from the timer flags and the
// car sensor, and asks for a timer restart on every phase change.
// Assumes: farm_car is synchronous to clk.
module hfl_phase_fsm
    import hwy_farm_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   farm_car,
    input  logic   short_done,
    input  logic   long_done,
    output phase_t phase,
    output logic   restart
);
    phase_t phase_nx;

    // Next-phase selection and the restart request.
    always_comb begin
        phase_nx = phase;
        restart  = 1'b0;
        unique case (phase)
            PH_HWY_GO: if (long_done && farm_car) begin
                phase_nx = PH_HWY_WARN;
                restart  = 1'b1;
            end
            PH_HWY_WARN: if (short_done) begin
                phase_nx = PH_FARM_GO;
                restart  = 1'b1;
            end
            PH_FARM_GO: if (long_done || !farm_car) begin
                phase_nx = PH_FARM_WARN;
                restart  = 1'b1;
            end
            PH_FARM_WARN: if (short_done) begin
                phase_nx = PH_HWY_GO;
                restart  = 1'b1;
            end
            default: begin
                phase_nx = PH_HWY_GO;
                restart  = 1'b1;
            end
        endcase
    end

    // Phase register with synchronous reset to highway green.
    always_ff @(posedge clk) begin
        if (!rst_n)
            phase <= PH_HWY_GO;
        else
            phase <= phase_nx;
    end

    // R3
    hwy_min_green_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_HWY_GO && !(long_done && farm_car)) |=> phase == PH_HWY_GO);
    // R4
    hwy_warn_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_HWY_WARN && short_done) |=> phase == PH_FARM_GO);
    // R5
    farm_green_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_FARM_GO && (long_done || !farm_car)) |=> phase == PH_FARM_WARN);
    // R6
    farm_warn_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_FARM_WARN && short_done) |=> phase == PH_HWY_GO);

endmodule

// File: rtl/hfl_lamp_decode.sv
// Maps the current phase to one lamp triple per road.
// Assumes: phase is always one of the four legal codes.
module hfl_lamp_decode
    import hwy_farm_pkg::*;
(
    input  phase_t phase,
    output lamp_t  hwy,
    output lamp_t  farm
);
    // Lamp pattern for each phase.
    always_comb begin
        unique case (phase)
            PH_HWY_GO:    begin hwy = '{1'b1, 1'b0, 1'b0}; farm = '{1'b0, 1'b0, 1'b1}; end
            PH_HWY_WARN:  begin hwy = '{1'b0, 1'b1, 1'b0}; farm = '{1'b0, 1'b0, 1'b1}; end
            PH_FARM_GO:   begin hwy = '{1'b0, 1'b0, 1'b1}; farm = '{1'b1, 1'b0, 1'b0}; end
            PH_FARM_WARN: begin hwy = '{1'b0, 1'b0, 1'b1}; farm = '{1'b0, 1'b1, 1'b0}; end
            default:      begin hwy = '{1'b0, 1'b0, 1'b1}; farm = '{1'b0, 1'b0, 1'b1}; end
        endcase
    end
endmodule

// File: rtl/hwy_farm_signal_ctrl.sv
// Top level of the highway and farm road light controller. It wires the
// timer, the phase sequencer and the lamp decoder together.
// Assumes: synchronous active-low reset; farm_car already conditioned.
module hwy_farm_signal_ctrl
    import hwy_farm_pkg::*;
#(
    parameter int SHORT_CYC = 3,
    parameter int LONG_CYC  = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic farm_car,
    output logic hwy_grn,
    output logic hwy_yel,
    output logic hwy_red,
    output logic farm_grn,
    output logic farm_yel,
    output logic farm_red
);
    logic   short_done;
    logic   long_done;
    logic   restart;
    phase_t phase;
    lamp_t  hwy_l;
    lamp_t  farm_l;

    hfl_interval_timer #(
        .SHORT_CYC(SHORT_CYC),
        .LONG_CYC (LONG_CYC)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart   (restart),
        .short_done(short_done),
        .long_done (long_done)
    );

    hfl_phase_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .farm_car  (farm_car),
        .short_done(short_done),
        .long_done (long_done),
        .phase     (phase),
        .restart   (restart)
    );

    hfl_lamp_decode u_dec (
        .phase(phase),
        .hwy  (hwy_l),
        .farm (farm_l)
    );

    // Drive the lamp ports from the decoded triples.
    always_comb begin
        {hwy_grn, hwy_yel, hwy_red}    = {hwy_l.grn, hwy_l.yel, hwy_l.red};
        {farm_grn, farm_yel, farm_red} = {farm_l.grn, farm_l.yel, farm_l.red};
    end

    // R2
    lamp_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones({hwy_grn, hwy_yel, hwy_red}) == 1) &&
        ($countones({farm_grn, farm_yel, farm_red}) == 1));
    // R2
    no_dual_green_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(hwy_grn && farm_grn));

endmodule

// File: tb/hwy_farm_signal_ctrl_test.sv
module hwy_farm_signal_ctrl_test;
    localparam int SH = 2;
    localparam int LG = 4;
    localparam logic [5:0] LS0 = 6'b100001;
    localparam logic [5:0] LS1 = 6'b010001;
    localparam logic [5:0] LS2 = 6'b001100;
    localparam logic [5:0] LS3 = 6'b001010;
    localparam int NV = 43;
    // {farm_car, expected lamps after the edge}
    localparam logic [6:0] VEC [NV] = '{
        {1'b1,LS0},{1'b1,LS0},{1'b1,LS0},{1'b1,LS0},{1'b1,LS1},
        {1'b1,LS1},{1'b1,LS1},{1'b1,LS2},{1'b1,LS2},{1'b1,LS2},
        {1'b1,LS2},{1'b1,LS2},{1'b1,LS3},{1'b0,LS3},{1'b0,LS3},
        {1'b0,LS0},{1'b1,LS0},{1'b1,LS0},{1'b1,LS0},{1'b0,LS0},
        {1'b0,LS0},{1'b0,LS0},{1'b1,LS1},{1'b0,LS1},{1'b0,LS1},
        {1'b0,LS2},{1'b0,LS3},{1'b1,LS3},{1'b1,LS3},{1'b1,LS0},
        {1'b1,LS0},{1'b1,LS0},{1'b1,LS0},{1'b1,LS0},{1'b1,LS1},
        {1'b1,LS1},{1'b1,LS1},{1'b1,LS2},{1'b1,LS2},{1'b0,LS3},
        {1'b0,LS3},{1'b0,LS3},{1'b0,LS0}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic farm_car = 1'b0;
    logic hwy_grn, hwy_yel, hwy_red, farm_grn, farm_yel, farm_red;
    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    hwy_farm_signal_ctrl #(.SHORT_CYC(SH), .LONG_CYC(LG)) uut (
        .clk(clk), .rst_n(rst_n), .farm_car(farm_car),
        .hwy_grn(hwy_grn), .hwy_yel(hwy_yel), .hwy_red(hwy_red),
        .farm_grn(farm_grn), .farm_yel(farm_yel), .farm_red(farm_red)
    );

    function automatic string req_of(input logic [5:0] l);
        if (l == LS1) return "R4";
        if (l == LS2) return "R5";
        if (l == LS3) return "R6";
        return "R3";
    endfunction

    task automatic check(input logic [5:0] exp, input string req);
        logic [5:0] act;
        act = {hwy_grn, hwy_yel, hwy_red, farm_grn, farm_yel, farm_red};
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s lamps act=%b exp=%b", req, act, exp);
        end
        n_chk++;
        if ($countones(act[5:3]) != 1 || $countones(act[2:0]) != 1) begin
            n_bad++;
            $display("FAIL R2 one-hot act=%b exp=one lamp per road", act);
        end
    endtask

    // One edge with the given sensor value; outputs sampled at the falling edge.
    task automatic step(input logic car);
        farm_car = car;
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        @(negedge clk);
        step(1'b1);
        step(1'b1);
        // R1 reset state
        check(LS0, "R1");

        rst_n = 1'b1;
        // R3 R4 R5 R6 R7: table walk over several sensor patterns
        for (int i = 0; i < NV; i++) begin
            step(VEC[i][6]);
            check(VEC[i][5:0], req_of(VEC[i][5:0]));
        end

        // Reach farm green with a car present, then reset in the middle of it.
        for (int i = 0; i < 8; i++) step(1'b1);
        check(LS2, "R5");
        rst_n = 1'b0;
        step(1'b1);
        // R1 reset during farm green returns to highway green
        check(LS0, "R1");
        rst_n = 1'b1;
        // R1 full long interval of highway green after release
        for (int i = 0; i < LG; i++) begin
            step(1'b1);
            check(LS0, "R1");
        end
        step(1'b1);
        check(LS1, "R1");
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(8 * 5000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog act=hung exp=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule